// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations for 39-bit virtual addresses with 4 KiB pages. Each entry holds a 27-bit virtual page number, a 44-bit physical page number, an address-space tag and a global flag. A lookup returns, in the same cycle, either a hit with the 56-bit physical address or a miss. A miss tells the surrounding logic to start an external table walk. The walk result comes back through the fill port.

A control register holds the translation mode, the current address-space tag and the root page number. The root page number is passed on to the walker. Writing this register never flushes cached translations. The tag on each entry keeps translations from different address spaces apart, so switching contexts costs no refill.

Invalidation is explicit, through a fence port. A fence can target one page, one address space, one page within one address space, or everything. Global entries survive every fence that names an address space.

Top module: `tlb_xlate`

## Requirements
- R1: With mode 0 (bare), a lookup reports hit=1 and miss=0, and the physical address equals the virtual address zero-extended to 56 bits.
- R2: With mode 8, a lookup hits when a valid entry's page number equals vaddr[38:12] and either its tag equals the current tag or it is global. The physical address is then {ppn, vaddr[11:0]}. Otherwise the lookup reports miss=1 and hit=0. Both results appear in the same cycle as the request.
- R3: An accepted fill stores its page numbers and global flag with the current tag, and it can be looked up from the next cycle on.
- R4: A control register write updates the mode, the tag and the root page number (root_ppn_o) on the next cycle, and leaves every entry valid.
- R5: A fence with both zero flags set invalidates every entry, global ones included.
- R6: A fence with only the address zero flag set invalidates the non-global entries whose tag equals the fence tag.
- R7: A fence with only the tag zero flag set invalidates every entry, global or not, whose page number equals fence_vaddr_i[38:12].
- R8: A fence with neither zero flag set invalidates only the non-global entries that match both the page number and the tag.
- R9: A fill with fill_ok_i=0 is dropped. No entry changes, and no fault or other indication results.
- R10: A fill that matches a valid entry's page number (with the current tag, or with a global entry) overwrites that entry. Otherwise the fill goes to the lowest-indexed invalid entry. If no entry is invalid, the fill replaces the entry at a round-robin pointer, which starts at 0 and advances only on such a replacement.
- R11: While a fence is presented, a translating lookup reports a miss, and a fill in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 39 | Virtual address to translate |
| lkp_hit_o | output | 1 | Translation available |
| lkp_miss_o | output | 1 | Translation not cached |
| lkp_paddr_o | output | 56 | Physical address |
| fill_valid_i | input | 1 | Walker result present |
| fill_ok_i | input | 1 | Walker result is a valid translation |
| fill_vpn_i | input | 27 | Virtual page number of the fill |
| fill_ppn_i | input | 44 | Physical page number of the fill |
| fill_global_i | input | 1 | Fill is valid in all address spaces |
| csr_we_i | input | 1 | Control register write |
| csr_mode_i | input | 4 | Mode: 0 bare, 8 translate |
| csr_asid_i | input | 16 | Address-space tag to make current |
| csr_root_i | input | 44 | Root page number |
| root_ppn_o | output | 44 | Held root page number for the walker |
| fence_valid_i | input | 1 | Fence request |
| fence_vaddr_i | input | 39 | Fence address operand |
| fence_asid_i | input | 16 | Fence tag operand |
| fence_va_zero_i | input | 1 | Address operand is the zero register |
| fence_asid_zero_i | input | 1 | Tag operand is the zero register |

## Verification
A stale valid bit or a wrong tag shows up on the very next lookup of that page: the lookup hits when it should miss, or returns an old physical page. Because the lookup path has no registers, the error is visible in the same cycle the page is probed. A round-robin pointer that advances at the wrong time stays hidden until all entries are full. It then evicts the wrong page, so the bench fills the array completely and probes the survivors after each replacement.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 39;
  localparam int PA_W   = 56;
  localparam int PG_W   = 12;
  localparam int ASID_W = 16;
  localparam int MODE_W = 4;
  localparam int VPN_W  = VA_W - PG_W;
  localparam int PPN_W  = PA_W - PG_W;

  localparam logic [MODE_W-1:0] MODE_BARE = MODE_W'(0);
  localparam logic [MODE_W-1:0] MODE_XL39 = MODE_W'(8);

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic              glob;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_cmp.sv
module tlb_cmp
  import tlb_pkg::*;
(
  input  tlb_ent_t          ent_i,
  input  logic              valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              fence_valid_i,
  input  logic [VPN_W-1:0]  fence_vpn_i,
  input  logic [ASID_W-1:0] fence_asid_i,
  input  logic              fence_va_zero_i,
  input  logic              fence_asid_zero_i,
  output logic              lkp_match_o,
  output logic              fill_match_o,
  output logic              kill_o
);
  logic tag_ok, fva_hit, fas_hit;

  assign tag_ok       = ent_i.glob || (ent_i.asid == cur_asid_i);
  assign lkp_match_o  = valid_i && tag_ok && (ent_i.vpn == lkp_vpn_i);
  assign fill_match_o = valid_i && tag_ok && (ent_i.vpn == fill_vpn_i);

  assign fva_hit = (ent_i.vpn == fence_vpn_i);
  // global entries never match a tag-qualified fence
  assign fas_hit = !ent_i.glob && (ent_i.asid == fence_asid_i);

  always_comb begin
    unique case ({fence_va_zero_i, fence_asid_zero_i})
      2'b11:   kill_o = 1'b1;
      2'b10:   kill_o = fas_hit;
      2'b01:   kill_o = fva_hit;
      default: kill_o = fva_hit && fas_hit;
    endcase
    kill_o = kill_o && fence_valid_i && valid_i;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  match_i,
  input  logic          alloc_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] rr_q;
  logic          found_m, found_inv, use_rr;

  always_comb begin
    idx_o     = rr_q;
    found_m   = 1'b0;
    found_inv = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found_m && match_i[i]) begin
        idx_o   = IW'(i);
        found_m = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!found_m && !found_inv && !valid_i[i]) begin
        idx_o     = IW'(i);
        found_inv = 1'b1;
      end
    end
    use_rr = !found_m && !found_inv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && use_rr) rr_q <= (rr_q == IW'(N-1)) ? '0 : rr_q + 1'b1;
  end

  // R10: pointer moves only when a full array forces replacement
  assert_rr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && valid_i == '1 && match_i == '0) |=> $stable(rr_q));
  // R10: an allocation never lands on a valid slot while an invalid one exists
  assert_inv_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && match_i == '0 && valid_i != '1) |-> !valid_i[idx_o]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VA_W-1:0]   lkp_vaddr_i,
  output logic              lkp_hit_o,
  output logic              lkp_miss_o,
  output logic [PA_W-1:0]   lkp_paddr_o,
  input  logic              fill_valid_i,
  input  logic              fill_ok_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              fill_global_i,
  input  logic              csr_we_i,
  input  logic [MODE_W-1:0] csr_mode_i,
  input  logic [ASID_W-1:0] csr_asid_i,
  input  logic [PPN_W-1:0]  csr_root_i,
  output logic [PPN_W-1:0]  root_ppn_o,
  input  logic              fence_valid_i,
  input  logic [VA_W-1:0]   fence_vaddr_i,
  input  logic [ASID_W-1:0] fence_asid_i,
  input  logic              fence_va_zero_i,
  input  logic              fence_asid_zero_i
);
  tlb_ent_t          ent_q [NUM_ENT];
  logic [NUM_ENT-1:0] valid_q;
  logic [MODE_W-1:0] mode_q;
  logic [ASID_W-1:0] asid_q;
  logic [PPN_W-1:0]  root_q;

  logic [NUM_ENT-1:0] lkp_match, fill_match, kill;
  logic [IDX_W-1:0]   vic_idx;
  logic               do_fill, xlate, any_hit;
  logic [PPN_W-1:0]   hit_ppn;

  assign xlate   = (mode_q != MODE_BARE);
  assign do_fill = fill_valid_i && fill_ok_i && !fence_valid_i;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    tlb_cmp u_cmp (
      .ent_i            (ent_q[g]),
      .valid_i          (valid_q[g]),
      .lkp_vpn_i        (lkp_vaddr_i[VA_W-1:PG_W]),
      .fill_vpn_i       (fill_vpn_i),
      .cur_asid_i       (asid_q),
      .fence_valid_i    (fence_valid_i),
      .fence_vpn_i      (fence_vaddr_i[VA_W-1:PG_W]),
      .fence_asid_i     (fence_asid_i),
      .fence_va_zero_i  (fence_va_zero_i),
      .fence_asid_zero_i(fence_asid_zero_i),
      .lkp_match_o      (lkp_match[g]),
      .fill_match_o     (fill_match[g]),
      .kill_o           (kill[g])
    );
  end

  tlb_victim #(.N(NUM_ENT)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_q),
    .match_i(fill_match),
    .alloc_i(do_fill),
    .idx_o  (vic_idx)
  );

  always_comb begin
    hit_ppn = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (lkp_match[i]) hit_ppn = ent_q[i].ppn;
    end
    any_hit = (|lkp_match) && !fence_valid_i;
  end

  always_comb begin
    lkp_hit_o   = lkp_valid_i && (!xlate || any_hit);
    lkp_miss_o  = lkp_valid_i && xlate && !any_hit;
    if (!xlate)       lkp_paddr_o = {{(PA_W-VA_W){1'b0}}, lkp_vaddr_i};
    else if (any_hit) lkp_paddr_o = {hit_ppn, lkp_vaddr_i[PG_W-1:0]};
    else              lkp_paddr_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BARE;
      asid_q <= '0;
      root_q <= '0;
    end else if (csr_we_i) begin
      mode_q <= csr_mode_i;
      asid_q <= csr_asid_i;
      root_q <= csr_root_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (kill[i]) valid_q[i] <= 1'b0;
        if (do_fill && vic_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (do_fill && vic_idx == IDX_W'(i)) begin
        ent_q[i].vpn  <= fill_vpn_i;
        ent_q[i].ppn  <= fill_ppn_i;
        ent_q[i].asid <= asid_q;
        ent_q[i].glob <= fill_global_i;
      end
    end
  end

  assign root_ppn_o = root_q;

  assert_bare_nomiss_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && mode_q == MODE_BARE) |-> (lkp_hit_o && !lkp_miss_o));
  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_hit_o && lkp_miss_o));
  assert_fill_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_fill |=> valid_q[$past(vic_idx)]);
  assert_csr_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !fence_valid_i && !(fill_valid_i && fill_ok_i)) |=> $stable(valid_q));
  assert_fence_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fence_va_zero_i && fence_asid_zero_i) |=> (valid_q == '0));
  assert_bad_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_ok_i && !fence_valid_i) |=> $stable(valid_q));
  assert_fence_miss_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && lkp_valid_i && xlate) |-> lkp_miss_o);
  assert_fence_nofill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_valid_i |=> ($countones(valid_q) <= $countones($past(valid_q))));
endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  import tlb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lkp_valid = 1'b0;
  logic [VA_W-1:0]   lkp_vaddr = '0;
  logic              lkp_hit, lkp_miss;
  logic [PA_W-1:0]   lkp_paddr;
  logic              fill_valid = 1'b0, fill_ok = 1'b0, fill_glob = 1'b0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic              csr_we = 1'b0;
  logic [MODE_W-1:0] csr_mode = '0;
  logic [ASID_W-1:0] csr_asid = '0;
  logic [PPN_W-1:0]  csr_root = '0;
  logic [PPN_W-1:0]  root_ppn;
  logic              fence_valid = 1'b0, fence_vz = 1'b0, fence_az = 1'b0;
  logic [VA_W-1:0]   fence_vaddr = '0;
  logic [ASID_W-1:0] fence_asid = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_xlate dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vaddr_i(lkp_vaddr),
    .lkp_hit_o(lkp_hit), .lkp_miss_o(lkp_miss), .lkp_paddr_o(lkp_paddr),
    .fill_valid_i(fill_valid), .fill_ok_i(fill_ok), .fill_vpn_i(fill_vpn),
    .fill_ppn_i(fill_ppn), .fill_global_i(fill_glob),
    .csr_we_i(csr_we), .csr_mode_i(csr_mode), .csr_asid_i(csr_asid),
    .csr_root_i(csr_root), .root_ppn_o(root_ppn),
    .fence_valid_i(fence_valid), .fence_vaddr_i(fence_vaddr), .fence_asid_i(fence_asid),
    .fence_va_zero_i(fence_vz), .fence_asid_zero_i(fence_az)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] va(input logic [VPN_W-1:0] vpn, input logic [PG_W-1:0] off);
    return {vpn, off};
  endfunction

  // probe between edges; expect hit with ppn, or miss
  task automatic probe(input string req, input logic [VPN_W-1:0] vpn, input bit exp_hit,
                       input logic [PPN_W-1:0] ppn);
    lkp_valid = 1'b1;
    lkp_vaddr = va(vpn, 12'h5a4);
    #1;
    chk({req, " hit"}, 64'(lkp_hit), 64'(exp_hit));
    chk({req, " miss"}, 64'(lkp_miss), 64'(!exp_hit));
    if (exp_hit) chk({req, " paddr"}, 64'(lkp_paddr), 64'({ppn, 12'h5a4}));
    lkp_valid = 1'b0;
  endtask

  task automatic wr_csr(input logic [MODE_W-1:0] m, input logic [ASID_W-1:0] a,
                        input logic [PPN_W-1:0] r);
    @(negedge clk);
    csr_we = 1'b1; csr_mode = m; csr_asid = a; csr_root = r;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input bit g, input bit ok);
    @(negedge clk);
    fill_valid = 1'b1; fill_ok = ok; fill_vpn = vpn; fill_ppn = ppn; fill_glob = g;
    @(negedge clk);
    fill_valid = 1'b0; fill_ok = 1'b0;
  endtask

  task automatic fence(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] a,
                       input bit vz, input bit az);
    @(negedge clk);
    fence_valid = 1'b1; fence_vaddr = va(vpn, 12'h0); fence_asid = a;
    fence_vz = vz; fence_az = az;
    @(negedge clk);
    fence_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R4 root after reset", 64'(root_ppn), 64'h0);
    lkp_valid = 1'b1; lkp_vaddr = 39'h12_3456_789a;
    #1;
    chk("R1 bare hit", 64'(lkp_hit), 64'h1);
    chk("R1 bare miss", 64'(lkp_miss), 64'h0);
    chk("R1 bare paddr", 64'(lkp_paddr), 64'h12_3456_789a);
    lkp_valid = 1'b0;
  endtask

  task automatic t_basic;
    wr_csr(4'd8, 16'd5, 44'h123);
    chk("R4 root", 64'(root_ppn), 64'h123);
    probe("R2 empty", 27'h10, 1'b0, '0);
    fill(27'h10, 44'hAAA, 1'b0, 1'b1);
    probe("R3 fill", 27'h10, 1'b1, 44'hAAA);
    probe("R2 other vpn", 27'h11, 1'b0, '0);
    fill(27'h20, 44'hBBB, 1'b1, 1'b1);
    probe("R3 global fill", 27'h20, 1'b1, 44'hBBB);
  endtask

  task automatic t_csr;
    wr_csr(4'd8, 16'd7, 44'h456);
    probe("R2 tag mismatch", 27'h10, 1'b0, '0);
    probe("R2 global other tag", 27'h20, 1'b1, 44'hBBB);
    wr_csr(4'd8, 16'd5, 44'h123);
    probe("R4 entry kept", 27'h10, 1'b1, 44'hAAA);
  endtask

  task automatic t_fence_tag;
    fill(27'h30, 44'hCCC, 1'b0, 1'b1);
    fence(27'h0, 16'd5, 1'b1, 1'b0);
    probe("R6 tag kill a", 27'h10, 1'b0, '0);
    probe("R6 tag kill b", 27'h30, 1'b0, '0);
    probe("R6 global kept", 27'h20, 1'b1, 44'hBBB);
  endtask

  task automatic t_fence_va;
    fill(27'h10, 44'hAAA, 1'b0, 1'b1);
    fence(27'h20, 16'd0, 1'b0, 1'b1);
    probe("R7 va kills global", 27'h20, 1'b0, '0);
    probe("R7 other va kept", 27'h10, 1'b1, 44'hAAA);
  endtask

  task automatic t_fence_both;
    fill(27'h20, 44'hBBB, 1'b1, 1'b1);
    fill(27'h30, 44'hC05, 1'b0, 1'b1);
    wr_csr(4'd8, 16'd9, 44'h123);
    fill(27'h30, 44'hC09, 1'b0, 1'b1);
    fence(27'h30, 16'd5, 1'b0, 1'b0);
    fence(27'h20, 16'd5, 1'b0, 1'b0);
    probe("R8 other tag kept", 27'h30, 1'b1, 44'hC09);
    probe("R8 global kept", 27'h20, 1'b1, 44'hBBB);
    wr_csr(4'd8, 16'd5, 44'h123);
    probe("R8 tagged page killed", 27'h30, 1'b0, '0);
    probe("R8 other page kept", 27'h10, 1'b1, 44'hAAA);
  endtask

  task automatic t_fence_all;
    fence(27'h0, 16'd0, 1'b1, 1'b1);
    probe("R5 all global", 27'h20, 1'b0, '0);
    probe("R5 all local", 27'h10, 1'b0, '0);
    wr_csr(4'd8, 16'd9, 44'h123);
    probe("R5 all other tag", 27'h30, 1'b0, '0);
    wr_csr(4'd8, 16'd5, 44'h123);
  endtask

  task automatic t_bad_fill;
    fill(27'h40, 44'hDDD, 1'b0, 1'b0);
    probe("R9 dropped", 27'h40, 1'b0, '0);
    fill(27'h41, 44'hEEE, 1'b0, 1'b1);
    fill(27'h41, 44'hFFF, 1'b0, 1'b0);
    probe("R9 no overwrite", 27'h41, 1'b1, 44'hEEE);
  endtask

  task automatic t_fence_cycle;
    @(negedge clk);
    fence_valid = 1'b1; fence_vaddr = va(27'h7777, 12'h0); fence_asid = 16'd3;
    fence_vz = 1'b0; fence_az = 1'b0;
    fill_valid = 1'b1; fill_ok = 1'b1; fill_vpn = 27'h50; fill_ppn = 44'h505; fill_glob = 1'b0;
    probe("R11 miss during fence", 27'h41, 1'b0, '0);
    @(negedge clk);
    fence_valid = 1'b0; fill_valid = 1'b0; fill_ok = 1'b0;
    probe("R11 fill dropped", 27'h50, 1'b0, '0);
    probe("R11 entry after fence", 27'h41, 1'b1, 44'hEEE);
  endtask

  task automatic t_replace;
    fence(27'h0, 16'd0, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) fill(27'h100 + 27'(i), 44'h200 + 44'(i), 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) probe("R10 full", 27'h100 + 27'(i), 1'b1, 44'h200 + 44'(i));
    fill(27'h108, 44'h208, 1'b0, 1'b1);
    probe("R10 rr evict slot0", 27'h100, 1'b0, '0);
    probe("R10 rr keep", 27'h101, 1'b1, 44'h201);
    probe("R10 rr new", 27'h108, 1'b1, 44'h208);
    fill(27'h109, 44'h209, 1'b0, 1'b1);
    probe("R10 rr evict slot1", 27'h101, 1'b0, '0);
    fill(27'h103, 44'h333, 1'b0, 1'b1);
    probe("R10 overwrite", 27'h103, 1'b1, 44'h333);
    probe("R10 overwrite no evict", 27'h102, 1'b1, 44'h202);
    fence(27'h105, 16'd0, 1'b0, 1'b1);
    fill(27'h10A, 44'h20A, 1'b0, 1'b1);
    probe("R10 invalid first new", 27'h10A, 1'b1, 44'h20A);
    probe("R10 invalid first keep a", 27'h102, 1'b1, 44'h202);
    probe("R10 invalid first keep b", 27'h104, 1'b1, 44'h204);
    probe("R10 invalid first keep c", 27'h109, 1'b1, 44'h209);
    fill(27'h10B, 44'h20B, 1'b0, 1'b1);
    probe("R10 rr resumes slot2", 27'h102, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_csr;
    t_fence_tag;
    t_fence_va;
    t_fence_both;
    t_fence_all;
    t_bad_fill;
    t_fence_cycle;
    t_replace;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule